// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is a full-duplex asynchronous serial transmitter and receiver whose character format is chosen at run time through static configuration inputs. The format covers five to eight data bits, five parity choices (even, odd, forced zero, forced one, none) and a stop length of one, one and a half or two bit times. All serial timing comes from a single-cycle enable, `tick16`, that an external divider pulses sixteen times per bit period.

A byte written into the one-entry transmit holding register moves to the shift register as soon as that register is idle. It is then sent LSB first after a low start bit. The receiver hunts for a falling edge, confirms the start bit at its midpoint and samples every later bit at its centre. It places the character in a one-entry receive holding register together with error flags for break, framing, parity and overrun. A 2-bit channel mode reroutes the serial lines for automatic echo, local loopback or remote loopback.

Top module: `uart_frame_engine`

## Requirements
- R1: `len_code` 00/01/10/11 selects 5/6/7/8 data bits, sent and received LSB first. Received characters are right-aligned in `rx_data`, with the unused upper bits zero.
- R2: `par_code[2]`=1 means no parity bit. Otherwise `par_code[1:0]` selects 00 even (total ones in data plus parity even), 01 odd, 10 parity bit always 0, 11 parity bit always 1. The parity bit follows the last data bit.
- R3: `stop_code` 4'hF gives two stop bits, 4'h8 to 4'hE give one and a half, and 4'h0 to 4'h7 give one. A frame lasts 16*(1+data+parity) plus 16, 24 or 32 ticks, measured from the start bit until `status[3]` rises.
- R4: `status` bit 7 is break, bit 6 framing error, bit 5 parity error, bit 4 overrun, bit 3 transmitter empty, bit 2 transmitter ready, and bits 1 and 0 are both receive holding register full.
- R5: Transmitter ready drops for at least the cycle after an accepted write. A write made while ready is low is dropped. Transmitter empty is high only when both the holding register and the shift register are idle, and `txd` idles high.
- R6: The receiver re-samples the start bit eight ticks after the falling edge and returns to hunting if the line is high, so a low pulse of two ticks yields no character.
- R7: A character with a wrong parity bit sets the parity-error flag, and a nonzero character with a low first stop bit sets the framing-error flag. Such characters are still delivered.
- R8: A character time received all zero (data, parity and first stop bit) sets the break flag, with data 0 and no framing flag. No further character is received until the line has returned high.
- R9: A character completing while the holding register is full sets overrun and is dropped, and the older character is kept. A read in the very cycle of completion lets the new character in without overrun.
- R10: A pulse on `err_clr` clears the four error flags. `rx_err` is high exactly while any of them is set.
- R11: `chan_mode` 00 is normal. 01 echoes `rxd` on `txd` while the receiver still works. 10 feeds the transmitter into the receiver, holds `txd` high and ignores `rxd`. 11 echoes `rxd` on `txd` with the receiver seeing an idle line.
- R12: After reset `status` is 8'h0C, `txd` is high and `rx_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | Sixteen-per-bit timing enable |
| len_code | input | 2 | Data length select |
| par_code | input | 3 | Parity select |
| stop_code | input | 4 | Stop length select |
| chan_mode | input | 2 | Channel routing mode |
| tx_wr | input | 1 | Write pulse for the transmit holding register |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Read pulse, frees the receive holding register |
| err_clr | input | 1 | Clears the error flags |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| rx_data | output | 8 | Received character |
| status | output | 8 | Status byte |
| rx_err | output | 1 | Any receive error flag set |

## Verification
Completion of a received character and a read of the receive holding register can fall in the same clock cycle. The read must then make room for the new character instead of causing an overrun. The bench first sends one character into an empty register and counts the cycles until the ready flag rises. It then fills the register, repeats the identical stimulus at the same tick phase, and pulses the read across exactly that completion edge. It judges the result by the new character being present with overrun clear.

// File: rtl/uart_frame_engine.sv
`timescale 1ns/1ps
module uart_frame_engine (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] len_code,
  input  logic [2:0] par_code,
  input  logic [3:0] stop_code,
  input  logic [1:0] chan_mode,
  input  logic       tx_wr,
  input  logic [7:0] tx_data,
  input  logic       rx_rd,
  input  logic       err_clr,
  input  logic       rxd,
  output logic       txd,
  output logic [7:0] rx_data,
  output logic [7:0] status,
  output logic       rx_err
);

  typedef enum logic [1:0] {R_IDLE, R_ACT, R_WAIT} rx_st_t;

  function automatic logic par_of(input logic [7:0] d, input logic [1:0] m);
    case (m)
      2'b00:   return ^d;
      2'b01:   return ~^d;
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  logic [3:0] nd;
  logic [7:0] dmask, stop_tk, tx_ticks, nbits;
  logic       par_on;

  assign nd      = 4'd5 + {2'b00, len_code};
  assign dmask   = 8'hFF >> (2'd3 - len_code);
  assign par_on  = ~par_code[2];
  assign stop_tk = (stop_code == 4'hF) ? 8'd32 : (stop_code[3] ? 8'd24 : 8'd16);
  assign nbits   = {4'd0, nd} + 8'd1 + {7'd0, par_on};
  assign tx_ticks = (nbits << 4) + stop_tk;

  // transmit path
  logic [7:0] hold_q;
  logic       hold_v, tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_sub;
  logic [7:0] tx_cnt;
  logic [8:0] ext;
  logic       tx_line;

  always_comb begin
    ext = {1'b1, hold_q | ~dmask};
    if (par_on) ext[nd] = par_of(hold_q & dmask, par_code[1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hold_v  <= 1'b0;
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_sub  <= '0;
      tx_cnt  <= '0;
    end else begin
      if (!tx_busy && hold_v) begin
        tx_busy <= 1'b1;
        tx_sh   <= {ext, 1'b0};
        tx_sub  <= '0;
        tx_cnt  <= tx_ticks;
        hold_v  <= 1'b0;
      end else if (tx_busy && tick16) begin
        tx_sub <= tx_sub + 4'd1;
        if (tx_sub == 4'd15) tx_sh <= {1'b1, tx_sh[9:1]};
        if (tx_cnt == 8'd1) tx_busy <= 1'b0;
        tx_cnt <= tx_cnt - 8'd1;
      end
      if (tx_wr && !hold_v) begin
        hold_v <= 1'b1;
        hold_q <= tx_data;
      end
    end
  end

  assign tx_line = tx_busy ? tx_sh[0] : 1'b1;

  // line routing
  logic [1:0] pin_s;
  logic       rx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_s <= 2'b11;
    else        pin_s <= {pin_s[0], rxd};
  end

  assign rx_in = (chan_mode == 2'b10) ? tx_line :
                 (chan_mode == 2'b11) ? 1'b1 : pin_s[1];
  assign txd   = chan_mode[0] ? pin_s[1] :
                 (chan_mode == 2'b10) ? 1'b1 : tx_line;

  // receive path
  rx_st_t     r_st;
  logic [3:0] r_sub, r_idx;
  logic [7:0] r_sh, dat_c, rx_q;
  logic       r_par, smp, rx_done, brk_c, fe_c, pe_c, load;
  logic       rx_full, f_brk, f_fe, f_pe, f_ovr;

  assign smp     = (r_st == R_ACT) && tick16 && (r_sub == 4'd7);
  assign rx_done = smp && (r_idx > nd + {3'd0, par_on});
  assign dat_c   = r_sh >> (4'd8 - nd);
  assign brk_c   = (dat_c == 8'd0) && !(par_on && r_par) && !rx_in;
  assign fe_c    = !rx_in && !brk_c;
  assign pe_c    = par_on && !brk_c && (r_par != par_of(dat_c, par_code[1:0]));
  assign load    = rx_done && (!rx_full || rx_rd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_st  <= R_IDLE;
      r_sub <= '0;
      r_idx <= '0;
      r_sh  <= '0;
      r_par <= 1'b0;
    end else begin
      case (r_st)
        R_IDLE: if (tick16 && !rx_in) begin
          r_st  <= R_ACT;
          r_sub <= '0;
          r_idx <= '0;
        end
        R_ACT: if (tick16) begin
          r_sub <= r_sub + 4'd1;
          if (r_sub == 4'd7) begin
            r_idx <= r_idx + 4'd1;
            if (r_idx == 4'd0) begin
              if (rx_in) r_st <= R_IDLE;
            end else if (r_idx <= nd) begin
              r_sh <= {rx_in, r_sh[7:1]};
            end else if (par_on && r_idx == nd + 4'd1) begin
              r_par <= rx_in;
            end else begin
              r_st <= rx_in ? R_IDLE : R_WAIT;
            end
          end
        end
        default: if (rx_in) r_st <= R_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_full <= 1'b0;
      f_brk   <= 1'b0;
      f_fe    <= 1'b0;
      f_pe    <= 1'b0;
      f_ovr   <= 1'b0;
    end else begin
      if (load) begin
        rx_q    <= dat_c;
        rx_full <= 1'b1;
      end else if (rx_rd) begin
        rx_full <= 1'b0;
      end
      f_brk <= (f_brk & ~err_clr) | (load & brk_c);
      f_fe  <= (f_fe  & ~err_clr) | (load & fe_c);
      f_pe  <= (f_pe  & ~err_clr) | (load & pe_c);
      f_ovr <= (f_ovr & ~err_clr) | (rx_done & ~load);
    end
  end

  assign rx_data = rx_q;
  assign status  = {f_brk, f_fe, f_pe, f_ovr, !hold_v && !tx_busy, !hold_v, rx_full, rx_full};
  assign rx_err  = f_brk | f_fe | f_pe | f_ovr;

endmodule

// File: rtl/uart_frame_engine_chk.sv
`timescale 1ns/1ps
module uart_frame_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chan_mode,
  input logic       tx_wr,
  input logic       txd,
  input logic [7:0] status
);

  AST_EMPTY_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[2]); // R5

  AST_RX_FLAGS_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] == status[0]); // R4

  AST_LOCAL_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    chan_mode == 2'b10 |-> txd); // R11

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'b00 && status[3]) |-> txd); // R5

  AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr && status[2]) |=> !status[2]); // R5

  AST_OVR_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> status[0]); // R9

endmodule

bind uart_frame_engine uart_frame_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chan_mode(chan_mode),
  .tx_wr(tx_wr), .txd(txd), .status(status)
);

// File: tb/uart_frame_engine_bench.sv
`timescale 1ns/1ps
module uart_frame_engine_bench;

  logic       clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0;
  logic [1:0] len_code = 2'd3;
  logic [2:0] par_code = 3'b100;
  logic [3:0] stop_code = 4'h7;
  logic [1:0] chan_mode = 2'b00;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, err_clr = 1'b0, rxd = 1'b1;
  logic [7:0] tx_data = '0;
  logic       txd, rx_err;
  logic [7:0] rx_data, status;

  int n_chk = 0, n_fail = 0, cyc = 0;

  uart_frame_engine u_uart_frame_engine (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .len_code(len_code),
    .par_code(par_code), .stop_code(stop_code), .chan_mode(chan_mode),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .err_clr(err_clr),
    .rxd(rxd), .txd(txd), .rx_data(rx_data), .status(status), .rx_err(rx_err)
  );

  always #2 clk = ~clk;

  initial forever begin
    @(posedge clk);
    #1;
    cyc = cyc + 1;
    tick16 = (cyc % 4 == 0);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // {len[1:0], par[2:0], stop[3:0], data[7:0]}
  localparam logic [16:0] VEC [8] = '{
    {2'd3, 3'b100, 4'h7, 8'hA5},
    {2'd3, 3'b000, 4'h7, 8'h53},
    {2'd3, 3'b001, 4'h8, 8'h07},
    {2'd0, 3'b011, 4'hF, 8'hFF},
    {2'd1, 3'b010, 4'h7, 8'hC9},
    {2'd2, 3'b000, 4'hF, 8'h31},
    {2'd3, 3'b001, 4'h8, 8'h00},
    {2'd0, 3'b100, 4'h3, 8'h12}
  };

  function automatic logic ref_par(input logic [7:0] d, input logic [1:0] m);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    case (m)
      2'b00:   return logic'(ones % 2);
      2'b01:   return logic'(1 - ones % 2);
      2'b10:   return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] msk(input logic [1:0] l);
    return 8'hFF >> (3 - int'(l));
  endfunction

  function automatic int nbits(input logic [1:0] l, input logic [2:0] p);
    return 1 + 5 + int'(l) + (p[2] ? 0 : 1) + 1;
  endfunction

  function automatic logic [11:0] mkf(input logic [7:0] d, input logic [1:0] l, input logic [2:0] p);
    logic [11:0] b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < 5 + int'(l); i++) b[1 + i] = d[i];
    if (!p[2]) b[6 + int'(l)] = ref_par(d & msk(l), p[1:0]);
    return b;
  endfunction

  task automatic send(input logic [11:0] b, input int n, input int mon);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      repeat (32) @(negedge clk);
      if (mon == 1) chk("R11 echo on txd", {31'd0, txd}, {31'd0, b[i]});
      if (mon == 2) chk("R11 txd mark in local loop", {31'd0, txd}, 32'd1);
      repeat (32) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    tx_data = d; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic rd();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
  endtask

  task automatic clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic wait_rx(input string tag);
    int i;
    for (i = 0; i < 4000; i++) begin
      if (status[0]) break;
      @(negedge clk);
    end
    chk(tag, {31'd0, status[0]}, 32'd1);
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 4000; i++) begin
      if (status[3]) break;
      @(negedge clk);
    end
  endtask

  task automatic align();
    @(negedge clk);
    while (cyc % 4 != 1) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d, got, m;
    logic [1:0] l;
    logic [2:0] p;
    logic [3:0] s;
    int nd, t, dur, fall, ncyc;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 R4 reset status", {24'd0, status}, 32'h0C);
    chk("R12 reset txd", {31'd0, txd}, 32'd1);
    chk("R12 reset rx_err", {31'd0, rx_err}, 32'd0);

    foreach (VEC[v]) begin
      l = VEC[v][16:15]; p = VEC[v][14:12]; s = VEC[v][11:8]; d = VEC[v][7:0];
      m = msk(l); nd = 5 + int'(l);
      len_code = l; par_code = p; stop_code = s;
      chan_mode = 2'b10;
      @(negedge clk);
      wr(d);
      wait_rx("R11 local loop delivers");
      chk("R1 R2 loop data", {24'd0, rx_data}, {24'd0, d & m});
      chk("R7 loop no errors", {28'd0, status[7:4]}, 32'd0);
      rd();
      wait_empty();
      chan_mode = 2'b00;
      @(negedge clk);
      wr(d);
      fall = 0;
      for (int i = 0; i < 100; i++) begin
        if (txd == 1'b0) begin fall = cyc; break; end
        @(negedge clk);
      end
      repeat (32) @(negedge clk);
      chk("R1 start bit low", {31'd0, txd}, 32'd0);
      got = '0;
      for (int k = 0; k < nd; k++) begin
        repeat (64) @(negedge clk);
        got[k] = txd;
      end
      chk("R1 serial data LSB first", {24'd0, got}, {24'd0, d & m});
      if (!p[2]) begin
        repeat (64) @(negedge clk);
        chk("R2 parity bit", {31'd0, txd}, {31'd0, ref_par(d & m, p[1:0])});
      end
      repeat (64) @(negedge clk);
      chk("R3 stop bit high", {31'd0, txd}, 32'd1);
      wait_empty();
      dur = cyc - fall;
      t = 16 * (nbits(l, p) - 1) + ((s == 4'hF) ? 32 : (s[3] ? 24 : 16));
      chk("R3 frame length", dur, (dur >= 4 * t - 3 && dur <= 4 * t) ? dur : 4 * t);
    end

    len_code = 2'd3; par_code = 3'b100; stop_code = 4'h7;
    chan_mode = 2'b10;
    @(negedge clk);
    wr(8'h3A);
    chk("R5 ready low after write", {31'd0, status[2]}, 32'd0);
    @(negedge clk);
    chk("R5 ready back once shifter loaded", {31'd0, status[2]}, 32'd1);
    chk("R5 empty low while shifting", {31'd0, status[3]}, 32'd0);
    wr(8'hB4);
    wr(8'hCC);
    wait_rx("R5 first byte");
    chk("R5 first byte data", {24'd0, rx_data}, 32'h3A);
    rd();
    wait_rx("R5 second byte");
    chk("R5 second byte data", {24'd0, rx_data}, 32'hB4);
    rd();
    repeat (2000) @(negedge clk);
    chk("R5 write while full dropped", {31'd0, status[0]}, 32'd0);
    chk("R5 empty at end", {31'd0, status[3]}, 32'd1);

    chan_mode = 2'b00;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R6 glitch rejected", {31'd0, status[0]}, 32'd0);
    send(mkf(8'h96, 2'd3, 3'b100), 10, 0);
    wait_rx("R6 receive after glitch");
    chk("R6 data after glitch", {24'd0, rx_data}, 32'h96);
    rd();

    par_code = 3'b000;
    @(negedge clk);
    send(12'b1_0_00000001_0, 11, 0);
    wait_rx("R7 parity frame");
    chk("R7 parity error flag", {28'd0, status[7:4]}, 32'h2);
    chk("R7 parity char kept", {24'd0, rx_data}, 32'h01);
    chk("R10 rx_err set", {31'd0, rx_err}, 32'd1);
    clr();
    chk("R10 flags cleared", {28'd0, status[7:4]}, 32'd0);
    chk("R10 rx_err cleared", {31'd0, rx_err}, 32'd0);
    rd();

    par_code = 3'b100;
    @(negedge clk);
    send(12'b0_00111100_0, 10, 0);
    wait_rx("R7 framing frame");
    chk("R7 framing flag only", {28'd0, status[7:4]}, 32'h4);
    chk("R7 framing char kept", {24'd0, rx_data}, 32'h3C);
    clr();
    rd();

    par_code = 3'b000;
    @(negedge clk);
    rxd = 1'b0;
    repeat (17 * 64) @(negedge clk);
    chk("R8 break char present", {31'd0, status[0]}, 32'd1);
    chk("R8 break flag only", {28'd0, status[7:4]}, 32'h8);
    chk("R8 break data zero", {24'd0, rx_data}, 32'd0);
    rd();
    rxd = 1'b1;
    repeat (500) @(negedge clk);
    chk("R8 single char for long break", {31'd0, status[0]}, 32'd0);
    clr();

    par_code = 3'b100;
    @(negedge clk);
    send(mkf(8'h11, 2'd3, 3'b100), 10, 0);
    send(mkf(8'h22, 2'd3, 3'b100), 10, 0);
    repeat (100) @(negedge clk);
    chk("R9 overrun flag", {31'd0, status[4]}, 32'd1);
    chk("R9 older char kept", {24'd0, rx_data}, 32'h11);
    clr();
    rd();

    align();
    ncyc = 0;
    fork
      send(mkf(8'h33, 2'd3, 3'b100), 10, 0);
      begin
        while (!status[0] && ncyc < 2000) begin
          @(negedge clk);
          ncyc++;
        end
      end
    join
    rd();
    send(mkf(8'h44, 2'd3, 3'b100), 10, 0);
    wait_rx("R9 holding filled");
    align();
    fork
      send(mkf(8'h55, 2'd3, 3'b100), 10, 0);
      begin
        repeat (ncyc - 1) @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk("R9 read with completion keeps full", {31'd0, status[0]}, 32'd1);
        chk("R9 read with completion takes new", {24'd0, rx_data}, 32'h55);
        chk("R9 read with completion no overrun", {31'd0, status[4]}, 32'd0);
      end
    join
    rd();

    chan_mode = 2'b01;
    @(negedge clk);
    send(mkf(8'h5A, 2'd3, 3'b100), 10, 1);
    wait_rx("R11 echo mode receives");
    chk("R11 echo data", {24'd0, rx_data}, 32'h5A);
    rd();

    chan_mode = 2'b11;
    @(negedge clk);
    send(mkf(8'hA6, 2'd3, 3'b100), 10, 1);
    repeat (200) @(negedge clk);
    chk("R11 remote loop receiver idle", {31'd0, status[0]}, 32'd0);

    chan_mode = 2'b10;
    @(negedge clk);
    send(mkf(8'h77, 2'd3, 3'b100), 10, 2);
    repeat (200) @(negedge clk);
    chk("R11 local loop ignores rxd", {31'd0, status[0]}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule